// File: doc/BRIEF.md
# Frame-Counting Bus-Kicked Reset Watchdog

This block produces the active-low reset for a 68000-style processor board. It has two sources of reset. The first is a power-good level from a supply monitor, which passes through a two-flop synchronizer. The second is a watchdog that counts video vertical-blanking pulses. The output reset is low whenever either source asks for it. While the supply is not good, the watchdog count is held at zero. Counting starts once power is declared good.

Software keeps the board running by writing to a fixed 128 KiB bus window often enough. Any write that decodes into that window clears the frame count, and the data value plays no part. If 128 frames pass without such a write, the count reaches its top bit. The processor is then held in reset for a fixed number of system clocks, after which the count starts again from zero. A strap input can keep the count cleared at all times, which disables the watchdog.

Top module: `frame_watchdog_rst`

## Requirements
- R1: While the synchronous active-high `rst` is high, `cpu_reset_n` is 0.
- R2: `supply_ok` passes through two clock flops. When `supply_ok` rises, `cpu_reset_n` is still 0 one clock later and is 1 after the second clock edge. At all times `cpu_reset_n` is 0 whenever the synchronized power-good is 0.
- R3: While the synchronized power-good is low, the frame count is held at zero and vertical-blanking pulses are not counted. After power returns, a timeout needs a full 128 new pulses.
- R4: The count advances once per rising edge of `vblank`, which is synchronized by two flops and then edge-detected. Holding `vblank` high for many clocks counts as one edge.
- R5: The 128th counted edge without a clear drives `cpu_reset_n` low for exactly 16 consecutive clocks. The count then returns to zero, so the next timeout needs another 128 edges.
- R6: A clear happens when `as_n`=0, `wr`=1 and `bus_ack`=1 in the same clock, with `addr[23:17]` equal to 7'b0011110 (byte addresses 0x3C0000 through 0x3DFFFF, with A16 and the lower bits don't-care). That clock zeroes the count.
- R7: A cycle with the address outside that window, or with `as_n`=1, `wr`=0 or `bus_ack`=0, leaves the count unchanged.
- R8: While `wd_disable`=1 the count is held at zero, so no number of frames causes a watchdog reset.
- R9: When a clear and a counted `vblank` edge fall in the same clock, the clear wins and the count is zero afterwards.
- R10: While the watchdog reset pulse is active, the count is frozen and bus clears are ignored, so the pulse always lasts its full 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Power-good level from the supply monitor, high when the supply is good (asynchronous) |
| vblank | input | 1 | Vertical-blanking level from video timing (asynchronous) |
| addr | input | 24 | Processor byte address |
| as_n | input | 1 | Active-low address strobe |
| wr | input | 1 | High for a write cycle |
| bus_ack | input | 1 | Bus acknowledge qualifier for the clear decode |
| wd_disable | input | 1 | Strap that holds the watchdog cleared |
| cpu_reset_n | output | 1 | Active-low processor reset |

## Verification
The bound checker verifies several properties on every cycle. The count either steps by one or drops to zero. The count is zero in the cycle after power-good is low, after the strap is set, or after a clear was accepted, and a clear beats a simultaneous frame edge. The count stays frozen while the reset pulse runs, and the reset follows a low supply input two clocks later. Some behaviours only the bench's scenarios can show, because they are observed at the reset port over hundreds of frames: the exact 128-frame threshold, the 16-clock pulse length, the restart from zero afterwards, single counting of a long `vblank` level, and which bus cycles fall inside or outside the clear window.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int ADDR_W = 24;

    // 128 KiB clear window: addr[23:17] must equal 7'b0011110
    localparam logic [ADDR_W-1:0] KICK_BASE = 24'h3C0000;
    localparam logic [ADDR_W-1:0] KICK_MASK = 24'hFE0000;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              strobe_n;
        logic              write;
        logic              ack;
    } bus_cycle_t;

    typedef struct packed {
        logic clear;
        logic step;
    } ctr_cmd_t;

    function automatic logic in_kick_window(input logic [ADDR_W-1:0] a);
        return (a & KICK_MASK) == KICK_BASE;
    endfunction

endpackage

// File: rtl/fwd_sync.sv
module fwd_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[DEPTH-2:0], d};
    end

    assign q = chain[DEPTH-1];
endmodule

// File: rtl/fwd_kick_decode.sv
module fwd_kick_decode
    import fwd_pkg::*;
(
    input  bus_cycle_t bus,
    output logic       kick
);
    assign kick = !bus.strobe_n && bus.write && bus.ack && in_kick_window(bus.addr);
endmodule

// File: rtl/fwd_frame_counter.sv
module fwd_frame_counter
    import fwd_pkg::*;
#(
    parameter int STAGE_W  = 4,
    parameter int N_STAGES = 2,
    localparam int CNT_W   = STAGE_W * N_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  ctr_cmd_t         cmd,
    output logic [CNT_W-1:0] count
);
    logic [N_STAGES:0] carry;
    assign carry[0] = cmd.step;

    // Cascaded binary stages: each advances when every lower stage wraps
    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        logic [STAGE_W-1:0] nib;
        always_ff @(posedge clk) begin
            if (rst || cmd.clear) nib <= '0;
            else if (carry[i])    nib <= nib + STAGE_W'(1);
        end
        assign carry[i+1] = carry[i] && (&nib);
        assign count[i*STAGE_W +: STAGE_W] = nib;
    end
endmodule

// File: rtl/frame_watchdog_rst.sv
module frame_watchdog_rst
    import fwd_pkg::*;
#(
    parameter int STAGE_W     = 4,
    parameter int N_STAGES    = 2,
    parameter int HOLD_CYCLES = 16,
    parameter int SYNC_DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              vblank,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              wr,
    input  logic              bus_ack,
    input  logic              wd_disable,
    output logic              cpu_reset_n
);
    localparam int CNT_W  = STAGE_W * N_STAGES;
    localparam int HOLD_W = $clog2(HOLD_CYCLES);

    logic             pg_q;
    logic             vb_s;
    logic             vb_d;
    logic             vb_edge;
    logic             kick;
    logic             fire;
    logic             hold_last;
    logic [HOLD_W-1:0] hold_cnt;
    logic [CNT_W-1:0] count;
    bus_cycle_t       bus;
    ctr_cmd_t         cmd;

    fwd_sync #(.DEPTH(SYNC_DEPTH)) u_pg_sync (
        .clk(clk), .rst(rst), .d(supply_ok), .q(pg_q)
    );

    fwd_sync #(.DEPTH(SYNC_DEPTH)) u_vb_sync (
        .clk(clk), .rst(rst), .d(vblank), .q(vb_s)
    );

    always_ff @(posedge clk) begin
        if (rst) vb_d <= 1'b0;
        else     vb_d <= vb_s;
    end
    assign vb_edge = vb_s && !vb_d;

    assign bus = '{addr: addr, strobe_n: as_n, write: wr, ack: bus_ack};

    fwd_kick_decode u_decode (.bus(bus), .kick(kick));

    // Top count bit marks timeout; hold it for HOLD_CYCLES, then restart
    assign fire      = count[CNT_W-1];
    assign hold_last = hold_cnt == HOLD_W'(HOLD_CYCLES - 1);

    always_comb begin
        cmd.clear = !pg_q || wd_disable || (kick && !fire) || (fire && hold_last);
        cmd.step  = vb_edge && !fire;
    end

    fwd_frame_counter #(.STAGE_W(STAGE_W), .N_STAGES(N_STAGES)) u_counter (
        .clk(clk), .rst(rst), .cmd(cmd), .count(count)
    );

    always_ff @(posedge clk) begin
        if (rst || !fire)   hold_cnt <= '0;
        else if (hold_last) hold_cnt <= '0;
        else                hold_cnt <= hold_cnt + HOLD_W'(1);
    end

    assign cpu_reset_n = pg_q && !fire;
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
    parameter int CNT_W      = 8,
    parameter int SYNC_DEPTH = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             supply_ok,
    input logic             wd_disable,
    input logic             cpu_reset_n,
    input logic             pg,
    input logic             kick,
    input logic             fire,
    input logic [CNT_W-1:0] count
);
    if (SYNC_DEPTH == 2) begin : g_r2
        // R2: a low supply input forces reset two edges later
        a_r2_supply_low_resets: assert property (@(posedge clk) disable iff (rst)
            !$past(supply_ok, 2) |-> !cpu_reset_n);
    end

    // R3: no power-good means a zero count next cycle
    a_r3_pg_low_clears: assert property (@(posedge clk) disable iff (rst)
        !$past(pg) |-> count == '0);

    // R4: count only steps by one or returns to zero
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        count != $past(count) |-> (count == '0 || count == $past(count) + CNT_W'(1)));

    // R8: strap keeps the count at zero
    a_r8_strap_clears: assert property (@(posedge clk) disable iff (rst)
        $past(wd_disable) |-> count == '0);

    // R9: an accepted clear wins over a frame edge
    a_r9_kick_wins: assert property (@(posedge clk) disable iff (rst)
        $past(kick && !fire) |-> count == '0);

    // R10: count frozen while the reset pulse runs
    a_r10_count_frozen: assert property (@(posedge clk) disable iff (rst)
        (fire && $past(fire)) |-> count == $past(count));
endmodule

bind frame_watchdog_rst fwd_checker #(.CNT_W(CNT_W), .SYNC_DEPTH(SYNC_DEPTH)) chk_i (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .wd_disable(wd_disable),
    .cpu_reset_n(cpu_reset_n), .pg(pg_q), .kick(kick), .fire(fire), .count(count)
);

// File: tb/frame_watchdog_rst_tb_top.sv
module frame_watchdog_rst_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        supply_ok = 1'b0;
    logic        vblank = 1'b0;
    logic [23:0] addr = '0;
    logic        as_n = 1'b1;
    logic        wr = 1'b0;
    logic        bus_ack = 1'b0;
    logic        wd_disable = 1'b0;
    logic        cpu_reset_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    frame_watchdog_rst dut_i (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .vblank(vblank),
        .addr(addr), .as_n(as_n), .wr(wr), .bus_ack(bus_ack),
        .wd_disable(wd_disable), .cpu_reset_n(cpu_reset_n)
    );

    typedef struct packed {
        logic [23:0] a;
        logic        s_n;
        logic        w;
        logic        k;
        logic        clears;
    } vec_t;

    // R6 / R7 bus cycles: each applied after 100 frames, then 28 more frames
    localparam vec_t VECS [11] = '{
        '{24'h3C0000, 1'b0, 1'b1, 1'b1, 1'b1},
        '{24'h3DFFFF, 1'b0, 1'b1, 1'b1, 1'b1},
        '{24'h3D1234, 1'b0, 1'b1, 1'b1, 1'b1},
        '{24'h3BFFFF, 1'b0, 1'b1, 1'b1, 1'b0},
        '{24'h3E0000, 1'b0, 1'b1, 1'b1, 1'b0},
        '{24'hBC0000, 1'b0, 1'b1, 1'b1, 1'b0},
        '{24'h7C0000, 1'b0, 1'b1, 1'b1, 1'b0},
        '{24'h380000, 1'b0, 1'b1, 1'b1, 1'b0},
        '{24'h3C0000, 1'b1, 1'b1, 1'b1, 1'b0},
        '{24'h3C0000, 1'b0, 1'b0, 1'b1, 1'b0},
        '{24'h3C0000, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic vb_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            vblank = 1'b1;
            repeat (3) @(negedge clk);
            vblank = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic bus_write(input logic [23:0] a, input logic s_n, input logic w, input logic k);
        addr = a; as_n = s_n; wr = w; bus_ack = k;
        @(negedge clk);
        addr = '0; as_n = 1'b1; wr = 1'b0; bus_ack = 1'b0;
    endtask

    task automatic fresh();
        supply_ok = 1'b0;
        repeat (4) @(negedge clk);
        supply_ok = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int lows;
        @(negedge clk);
        supply_ok = 1'b1;
        @(negedge clk);
        chk("R1 reset held during rst", cpu_reset_n, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 one clock after release", cpu_reset_n, 0);
        @(negedge clk);
        chk("R2 two clocks after release", cpu_reset_n, 1);

        // R2: supply drop propagates in two clocks
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R2 drop after one clock", cpu_reset_n, 1);
        @(negedge clk);
        chk("R2 drop after two clocks", cpu_reset_n, 0);
        supply_ok = 1'b1;
        repeat (3) @(negedge clk);

        // Vector table for R6 / R7
        foreach (VECS[v]) begin
            fresh();
            vb_pulses(100);
            bus_write(VECS[v].a, VECS[v].s_n, VECS[v].w, VECS[v].k);
            vb_pulses(28);
            chk(VECS[v].clears ? "R6 window write clears" : "R7 non-matching cycle ignored",
                cpu_reset_n, VECS[v].clears ? 1 : 0);
        end

        // R5: threshold, pulse length and restart
        fresh();
        vb_pulses(127);
        chk("R5 no reset after 127 frames", cpu_reset_n, 1);
        vblank = 1'b1;
        lows = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i == 3) vblank = 1'b0;
            if (!cpu_reset_n) lows++;
        end
        chk("R5 pulse length", lows, 16);
        chk("R5 released after pulse", cpu_reset_n, 1);
        vb_pulses(127);
        chk("R5 restart needs full span", cpu_reset_n, 1);
        vb_pulses(1);
        chk("R5 second timeout", cpu_reset_n, 0);

        // R10: clear during the pulse does not shorten it
        fresh();
        vb_pulses(127);
        vblank = 1'b1;
        lows = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i == 3) vblank = 1'b0;
            if (!cpu_reset_n) lows++;
            if (i == 8)  begin addr = 24'h3C0000; as_n = 1'b0; wr = 1'b1; bus_ack = 1'b1; end
            if (i == 9)  begin addr = '0; as_n = 1'b1; wr = 1'b0; bus_ack = 1'b0; end
        end
        chk("R10 pulse unaffected by clear", lows, 16);

        // R4: a long vblank level counts once
        fresh();
        vb_pulses(126);
        vblank = 1'b1;
        repeat (50) @(negedge clk);
        vblank = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 long level counted once", cpu_reset_n, 1);
        vb_pulses(1);
        chk("R4 timeout at 128th edge", cpu_reset_n, 0);

        // R9: clear and frame edge in the same clock
        fresh();
        vb_pulses(100);
        vblank = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = 24'h3C0000; as_n = 1'b0; wr = 1'b1; bus_ack = 1'b1;
        @(negedge clk);
        addr = '0; as_n = 1'b1; wr = 1'b0; bus_ack = 1'b0;
        vblank = 1'b0;
        repeat (3) @(negedge clk);
        vb_pulses(127);
        chk("R9 clear beats edge", cpu_reset_n, 1);
        vb_pulses(1);
        chk("R9 timeout after 128 more", cpu_reset_n, 0);

        // R3: frames ignored while supply is low
        fresh();
        vb_pulses(100);
        supply_ok = 1'b0;
        vb_pulses(5);
        chk("R3 reset while supply low", cpu_reset_n, 0);
        supply_ok = 1'b1;
        repeat (4) @(negedge clk);
        vb_pulses(127);
        chk("R3 count restarted at power good", cpu_reset_n, 1);
        vb_pulses(1);
        chk("R3 timeout after 128 new frames", cpu_reset_n, 0);

        // R8: strap disables the watchdog
        fresh();
        wd_disable = 1'b1;
        vb_pulses(140);
        chk("R8 no timeout while strapped", cpu_reset_n, 1);
        wd_disable = 1'b0;
        vb_pulses(127);
        chk("R8 counting from zero after strap", cpu_reset_n, 1);
        vb_pulses(1);
        chk("R8 timeout after strap release", cpu_reset_n, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule